// File: doc/BRIEF.md
# Microprogram Control Sequencer

This block steps the control unit of a small microprogrammed processor. It holds the 7-bit control address register and a one-entry return register, and it contains a 128-word control store. The store holds the instruction fetch routine, an indirect-address subroutine and the microcode for four memory-reference instructions. Each cycle the word addressed by the control address register is presented at the output. Its condition-select, branch-type and address fields, together with three status inputs from the datapath and the 4-bit opcode of the current instruction, choose the next control address.

The datapath decodes the three micro-operation fields of the presented word. It returns the indirect bit of the instruction, the sign and zero flags of the accumulator, and the opcode. The sequencer itself never touches datapath registers or main memory.

Top module: `micro_seq`

## Requirements
- R1: A synchronous active-high reset loads the control address with 64, so the word of address 64 is presented in the cycle after reset is released.
- R2: The 20-bit output word is the control-store word at the current control address, packed MSB first as op field A [19:17], op field B [16:14], op field C [13:11], condition select [10:9], branch type [8:7], branch address [6:0].
- R3: The fetch routine holds three words. Address 64 is A=6, jump to 65. Address 65 is B=4 and C=5, jump to 66. Address 66 is A=5 with branch type map. All three use condition 00 and branch address 0 where unused.
- R4: Branch type 11 (map) loads the control address with the opcode shifted left by two, which is 4*opcode, whatever the status inputs are.
- R5: Branch type 00 (jump) loads the branch address when the selected condition is true and the current address plus one otherwise. The condition select codes are 00 always true, 01 indirect bit, 10 accumulator sign and 11 accumulator zero.
- R6: Branch type 01 (call) with a true condition stores the current address plus one in the return register and loads the branch address, both in the same cycle. With a false condition it loads the current address plus one and leaves the return register unchanged.
- R7: Branch type 10 (return) loads the control address from the return register, whatever the status inputs are.
- R8: The indirect subroutine holds two words. Address 67 is B=4, jump to 68. Address 68 is A=5 with branch type return.
- R9: The four instruction routines hold the following words, each written as fields A,B,C,select,type,target. ADD starts at 0: (0,0,0,01,01,67), (0,4,0,00,00,2), (1,0,0,00,00,64). BRANCH starts at 4: (0,0,0,10,00,6), (0,0,0,00,00,64), (0,0,0,01,01,67), (0,0,6,00,00,64). STORE starts at 8: (0,0,0,01,01,67), (0,5,0,00,00,10), (7,0,0,00,00,64). EXCHANGE starts at 12: (0,0,0,01,01,67), (0,4,0,00,00,14), (4,5,0,00,00,15), (7,0,0,00,00,64).
- R10: Every other control-store word is all-zero operation fields with an always-true jump to 64, so unused opcodes return to the fetch routine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ind_bit | input | 1 | Indirect-addressing bit of the current instruction |
| ac_sign | input | 1 | Sign bit of the accumulator |
| ac_zero | input | 1 | Accumulator-is-zero flag |
| opcode | input | 4 | Operation code of the current instruction |
| car | output | 7 | Current control address |
| uword | output | 20 | Control-store word at the current control address |

## Verification
The control address is registered, and the output word is a purely combinational read of it. A wrong next-address choice therefore shows on `car` and `uword` at the very next clock edge. A corrupted return register stays hidden until the return word at 68 executes. It then appears one cycle later as a resume address other than the word after the call. A wrong store entry shows as a field mismatch in the cycle that word is addressed. If it is a branch field, the address sequence also diverges one cycle after that. Walking every opcode with both values of the indirect bit and of the sign flag compares the whole address trace against one computed from the routine layout. This exposes such faults within a few cycles of the fault.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int CAR_W = 7;
    localparam int OPC_W = 4;
    localparam int MAP_SH = 2;

    localparam logic [CAR_W-1:0] FETCH_ORG = 7'd64;
    localparam logic [CAR_W-1:0] INDIR_ORG = 7'd67;

    typedef enum logic [1:0] {
        CS_ALWAYS = 2'd0,
        CS_IND    = 2'd1,
        CS_SIGN   = 2'd2,
        CS_ZERO   = 2'd3
    } cond_sel_e;

    typedef enum logic [1:0] {
        BT_JUMP = 2'd0,
        BT_CALL = 2'd1,
        BT_RET  = 2'd2,
        BT_MAP  = 2'd3
    } branch_e;

    typedef enum logic [2:0] {
        A_NOP, A_ADD, A_CLR, A_INC, A_DR2AC, A_DR2AR, A_PC2AR, A_WRITE
    } opa_e;

    typedef enum logic [2:0] {
        B_NOP, B_SUB, B_OR, B_AND, B_READ, B_AC2DR, B_INCDR, B_PC2DR
    } opb_e;

    typedef enum logic [2:0] {
        C_NOP, C_XOR, C_COM, C_SHL, C_SHR, C_INCPC, C_AR2PC, C_RSVD
    } opc_e;

    typedef struct packed {
        opa_e             f1;
        opb_e             f2;
        opc_e             f3;
        cond_sel_e        cd;
        branch_e          br;
        logic [CAR_W-1:0] ad;
    } uword_t;

    localparam int UW_W = $bits(uword_t);

    function automatic uword_t mk(opa_e a, opb_e b, opc_e c,
                                  cond_sel_e s, branch_e t,
                                  logic [CAR_W-1:0] tgt);
        uword_t w;
        w.f1 = a;
        w.f2 = b;
        w.f3 = c;
        w.cd = s;
        w.br = t;
        w.ad = tgt;
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [CAR_W-1:0] addr,
    output uword_t           word
);

    localparam logic [CAR_W-1:0] NOWHERE = '0;

    always_comb begin
        word = mk(A_NOP, B_NOP, C_NOP, CS_ALWAYS, BT_JUMP, FETCH_ORG);
        case (int'(addr))
            // ADD
            0:  word = mk(A_NOP,   B_NOP,   C_NOP,   CS_IND,    BT_CALL, INDIR_ORG);
            1:  word = mk(A_NOP,   B_READ,  C_NOP,   CS_ALWAYS, BT_JUMP, 7'd2);
            2:  word = mk(A_ADD,   B_NOP,   C_NOP,   CS_ALWAYS, BT_JUMP, FETCH_ORG);
            // BRANCH
            4:  word = mk(A_NOP,   B_NOP,   C_NOP,   CS_SIGN,   BT_JUMP, 7'd6);
            5:  word = mk(A_NOP,   B_NOP,   C_NOP,   CS_ALWAYS, BT_JUMP, FETCH_ORG);
            6:  word = mk(A_NOP,   B_NOP,   C_NOP,   CS_IND,    BT_CALL, INDIR_ORG);
            7:  word = mk(A_NOP,   B_NOP,   C_AR2PC, CS_ALWAYS, BT_JUMP, FETCH_ORG);
            // STORE
            8:  word = mk(A_NOP,   B_NOP,   C_NOP,   CS_IND,    BT_CALL, INDIR_ORG);
            9:  word = mk(A_NOP,   B_AC2DR, C_NOP,   CS_ALWAYS, BT_JUMP, 7'd10);
            10: word = mk(A_WRITE, B_NOP,   C_NOP,   CS_ALWAYS, BT_JUMP, FETCH_ORG);
            // EXCHANGE
            12: word = mk(A_NOP,   B_NOP,   C_NOP,   CS_IND,    BT_CALL, INDIR_ORG);
            13: word = mk(A_NOP,   B_READ,  C_NOP,   CS_ALWAYS, BT_JUMP, 7'd14);
            14: word = mk(A_DR2AC, B_AC2DR, C_NOP,   CS_ALWAYS, BT_JUMP, 7'd15);
            15: word = mk(A_WRITE, B_NOP,   C_NOP,   CS_ALWAYS, BT_JUMP, FETCH_ORG);
            // fetch
            64: word = mk(A_PC2AR, B_NOP,   C_NOP,   CS_ALWAYS, BT_JUMP, 7'd65);
            65: word = mk(A_NOP,   B_READ,  C_INCPC, CS_ALWAYS, BT_JUMP, 7'd66);
            66: word = mk(A_DR2AR, B_NOP,   C_NOP,   CS_ALWAYS, BT_MAP,  NOWHERE);
            // indirect subroutine
            67: word = mk(A_NOP,   B_READ,  C_NOP,   CS_ALWAYS, BT_JUMP, 7'd68);
            68: word = mk(A_DR2AR, B_NOP,   C_NOP,   CS_ALWAYS, BT_RET,  NOWHERE);
            default: ;
        endcase
    end

endmodule

// File: rtl/useq_cond.sv
module useq_cond
    import useq_pkg::*;
(
    input  cond_sel_e sel,
    input  logic      ind_bit,
    input  logic      ac_sign,
    input  logic      ac_zero,
    output logic      hit
);

    always_comb begin
        unique case (sel)
            CS_ALWAYS: hit = 1'b1;
            CS_IND:    hit = ind_bit;
            CS_SIGN:   hit = ac_sign;
            CS_ZERO:   hit = ac_zero;
            default:   hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = CAR_W,
    parameter int OW = OPC_W,
    parameter int SH = MAP_SH
) (
    input  logic [AW-1:0] car,
    input  logic [AW-1:0] sbr,
    input  branch_e       br,
    input  logic [AW-1:0] ad,
    input  logic          hit,
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] car_d,
    output logic          sbr_we,
    output logic [AW-1:0] sbr_d
);

    logic [AW-1:0] inc;
    logic [AW-1:0] map_addr;

    assign inc = car + 1'b1;

    always_comb begin
        map_addr = '0;
        map_addr[OW+SH-1:SH] = opcode;
    end

    assign sbr_d = inc;

    always_comb begin
        sbr_we = 1'b0;
        unique case (br)
            BT_JUMP: car_d = hit ? ad : inc;
            BT_CALL: begin
                car_d  = hit ? ad : inc;
                sbr_we = hit;
            end
            BT_RET:  car_d = sbr;
            BT_MAP:  car_d = map_addr;
            default: car_d = inc;
        endcase
    end

endmodule

// File: rtl/micro_seq.sv
module micro_seq
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ind_bit,
    input  logic             ac_sign,
    input  logic             ac_zero,
    input  logic [OPC_W-1:0] opcode,
    output logic [CAR_W-1:0] car,
    output logic [UW_W-1:0]  uword
);

    logic [CAR_W-1:0] car_q;
    logic [CAR_W-1:0] sbr_q;
    logic [CAR_W-1:0] car_d;
    logic [CAR_W-1:0] sbr_d;
    logic             sbr_we;
    logic             hit;
    uword_t           cur;

    useq_store u_store (
        .addr (car_q),
        .word (cur)
    );

    useq_cond u_cond (
        .sel     (cur.cd),
        .ind_bit (ind_bit),
        .ac_sign (ac_sign),
        .ac_zero (ac_zero),
        .hit     (hit)
    );

    useq_next #(.AW(CAR_W), .OW(OPC_W), .SH(MAP_SH)) u_next (
        .car    (car_q),
        .sbr    (sbr_q),
        .br     (cur.br),
        .ad     (cur.ad),
        .hit    (hit),
        .opcode (opcode),
        .car_d  (car_d),
        .sbr_we (sbr_we),
        .sbr_d  (sbr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= FETCH_ORG;
            sbr_q <= '0;
        end else begin
            car_q <= car_d;
            if (sbr_we) sbr_q <= sbr_d;
        end
    end

    assign car   = car_q;
    assign uword = cur;

endmodule

// File: rtl/micro_seq_chk.sv
module micro_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        ind_bit,
    input logic        ac_sign,
    input logic        ac_zero,
    input logic [3:0]  opcode,
    input logic [6:0]  car,
    input logic [6:0]  sbr,
    input logic [19:0] uword
);

    logic [1:0] sel;
    logic [1:0] typ;
    logic [6:0] tgt;
    logic       cond_ok;

    assign sel = uword[10:9];
    assign typ = uword[8:7];
    assign tgt = uword[6:0];
    assign cond_ok = (sel == 2'd0) | ((sel == 2'd1) & ind_bit) |
                     ((sel == 2'd2) & ac_sign) | ((sel == 2'd3) & ac_zero);

    AST_RESET_FETCH: assert property (@(posedge clk) rst |=> car == 7'd64); // R1

    AST_MAP_OPCODE: assert property (@(posedge clk) disable iff (rst)
        typ == 2'd3 |=> car == {1'b0, $past(opcode), 2'b00}); // R4

    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (typ == 2'd0 && cond_ok) |=> car == $past(tgt)); // R5

    AST_JUMP_FALL: assert property (@(posedge clk) disable iff (rst)
        (typ == 2'd0 && !cond_ok) |=> car == $past(car) + 7'd1); // R5

    AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
        (typ == 2'd1 && cond_ok) |=> (car == $past(tgt) && sbr == $past(car) + 7'd1)); // R6

    AST_CALL_SKIP: assert property (@(posedge clk) disable iff (rst)
        (typ == 2'd1 && !cond_ok) |=> (car == $past(car) + 7'd1 && $stable(sbr))); // R6

    AST_RET_RESUME: assert property (@(posedge clk) disable iff (rst)
        typ == 2'd2 |=> car == $past(sbr)); // R7

endmodule

bind micro_seq micro_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ind_bit (ind_bit),
    .ac_sign (ac_sign),
    .ac_zero (ac_zero),
    .opcode  (opcode),
    .car     (car_q),
    .sbr     (sbr_q),
    .uword   (uword)
);

// File: tb/micro_seq_test.sv
module micro_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ind_bit = 1'b0;
    logic        ac_sign = 1'b0;
    logic        ac_zero = 1'b0;
    logic [3:0]  opcode = '0;
    logic [6:0]  car;
    logic [19:0] uword;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int tr [0:15];
    int tr_n;

    micro_seq uut (
        .clk     (clk),
        .rst     (rst),
        .ind_bit (ind_bit),
        .ac_sign (ac_sign),
        .ac_zero (ac_zero),
        .opcode  (opcode),
        .car     (car),
        .uword   (uword)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [19:0] w(int a, int b, int c, int s, int t, int g);
        return {a[2:0], b[2:0], c[2:0], s[1:0], t[1:0], g[6:0]};
    endfunction

    // expected store contents, from R3, R8, R9, R10
    function automatic logic [19:0] exp_word(int adr);
        case (adr)
            0:  return w(0,0,0,1,1,67);
            1:  return w(0,4,0,0,0,2);
            2:  return w(1,0,0,0,0,64);
            4:  return w(0,0,0,2,0,6);
            5:  return w(0,0,0,0,0,64);
            6:  return w(0,0,0,1,1,67);
            7:  return w(0,0,6,0,0,64);
            8:  return w(0,0,0,1,1,67);
            9:  return w(0,5,0,0,0,10);
            10: return w(7,0,0,0,0,64);
            12: return w(0,0,0,1,1,67);
            13: return w(0,4,0,0,0,14);
            14: return w(4,5,0,0,0,15);
            15: return w(7,0,0,0,0,64);
            64: return w(6,0,0,0,0,65);
            65: return w(0,4,5,0,0,66);
            66: return w(5,0,0,0,3,0);
            67: return w(0,4,0,0,0,68);
            68: return w(5,0,0,0,2,0);
            default: return w(0,0,0,0,0,64);
        endcase
    endfunction

    function automatic string word_tag(int adr);
        if (adr >= 64 && adr <= 66) return "R2 R3";
        if (adr == 67 || adr == 68) return "R2 R8";
        if (adr <= 15 && adr != 3 && adr != 11) return "R2 R9";
        return "R2 R10";
    endfunction

    function automatic string step_tag(int prev);
        if (prev == 66) return "R4";
        if (prev == 68) return "R7";
        if (prev == 0 || prev == 6 || prev == 8 || prev == 12) return "R6";
        return "R5";
    endfunction

    task automatic push(int a);
        tr[tr_n] = a;
        tr_n++;
    endtask

    task automatic build(int op, bit ind, bit sgn);
        tr_n = 0;
        push(64); push(65); push(66);
        push(op * 4);
        case (op)
            0: begin
                if (ind) begin push(67); push(68); end
                push(1); push(2);
            end
            1: begin
                if (sgn) begin
                    push(6);
                    if (ind) begin push(67); push(68); end
                    push(7);
                end else begin
                    push(5);
                end
            end
            2: begin
                if (ind) begin push(67); push(68); end
                push(9); push(10);
            end
            3: begin
                if (ind) begin push(67); push(68); end
                push(13); push(14); push(15);
            end
            default: ;
        endcase
        push(64);
    endtask

    task automatic check_car(string tag, int exp_a);
        checks++;
        if (int'(car) != exp_a) begin
            fails++;
            $display("FAIL %s car actual=%0d expected=%0d", tag, car, exp_a);
        end
    endtask

    task automatic check_word(int adr);
        logic [19:0] e;
        e = exp_word(adr);
        checks++;
        if (uword !== e) begin
            fails++;
            $display("FAIL %s word@%0d actual=%05h expected=%05h",
                     word_tag(adr), adr, uword, e);
        end
    endtask

    task automatic run_case(int op, bit ind, bit sgn, bit zro);
        build(op, ind, sgn);
        @(negedge clk);
        rst = 1'b1;
        opcode = op[3:0];
        ind_bit = ind;
        ac_sign = sgn;
        ac_zero = zro;
        @(negedge clk);
        rst = 1'b0;
        check_car("R1", 64);
        check_word(64);
        for (int i = 1; i < tr_n; i++) begin
            @(negedge clk);
            check_car(step_tag(tr[i-1]), tr[i]);
            check_word(tr[i]);
        end
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        // sweep every opcode with every indirect and sign combination
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 4; k++) begin
                run_case(op, k[0], k[1], k[0] ^ k[1]);
            end
        end
        // accumulator zero flag must not steer any stored word
        run_case(1, 1'b0, 1'b0, 1'b1);
        run_case(3, 1'b1, 1'b1, 1'b1);

        // reset taken inside the indirect subroutine returns to fetch (R1)
        @(negedge clk);
        rst = 1'b1;
        opcode = 4'd2;
        ind_bit = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_car("R6", 67);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_car("R1", 64);
        check_word(64);
        @(negedge clk);
        check_car("R5", 65);

        // opcode changed after map has no effect on the routine in flight (R4)
        rst = 1'b1;
        opcode = 4'd3;
        ind_bit = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_car("R4", 12);
        opcode = 4'd0;
        @(negedge clk);
        check_car("R5", 13);
        @(negedge clk);
        check_car("R5", 14);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule